// File: doc/BRIEF.md
# Chained Descriptor DMA Channel Controller

This block sequences one DMA channel through a list of transfer descriptors kept in host memory. Software programs a few registers: where the first descriptor block lives, a local address for the far end, and a start bit. The controller then reads a whole 128-word descriptor block over a simple memory read port. It checks the block's trailing signature word and its checksum. Only after that check passes does it request any data movement.

Each descriptor is a pair of words. The first word gives a host buffer address in 256-byte units. The second word holds flags. One flag marks the direction of the transfer. One flag says "carry on with the next descriptor". One flag says "the entry after this one points at another descriptor block". For each descriptor the controller hands a one-block (4 kB) request to an external data mover and waits for that mover's done pulse. Each finished block raises a sticky end-of-block flag. The end of the chain raises an end-of-transfer flag. Software clears either flag through a separate flag-clear register.

A rejected block ends the run at once with a distinct status value and moves no data. The last descriptor pair of each block is reserved for the signature word. Asking to continue past the 63rd descriptor therefore ends the chain as complete.

Top module: `dma_chain_ctrl`

## Requirements
- R1: After reset, status (register 16) reads 0x8000, and memRd, xferReq and fifoClr are all low. Status bit fields: 0 = run bit as written, 4 = end of block, 5 = end of transfer, 8 = descriptor block accepted, 13 = descriptor block rejected, 15 = controller idle.
- R2: The mode (8), descriptor address low (20), descriptor address high (21) and local address (23) registers read back what was written. The local address appears unchanged on xferLocalAddr with every request.
- R3: Writing control (register 9) with bit 0 set while idle reads the 128 words of the block at ascending word addresses. The reads start at the byte address in register 20.
- R4: A block is accepted only if all three checks hold. The low half of word 127 must be 0x4953. Word 126 must be zero. The high half of word 127 must equal the 16-bit wrap-around sum of every other halfword in the block. Acceptance sets status bit 8.
- R5: A rejected block leaves status at 0xA021 and raises no transfer request.
- R6: For descriptor i, words 2i and 2i+1 are read. The request host address is word0 shifted left by 8. xferToHost equals word1 bit 8.
- R7: After the mover's done pulse, word1 bit 0 selects the next descriptor. With bits 0 and 1 both clear, the chain ends and status bit 5 is set.
- R8: If word1 bit 1 is set, then after this descriptor's transfer the next entry's word0, shifted left by 8, becomes the new block address. That block is fetched, validated and walked from descriptor 0.
- R9: Every done pulse sets status bit 4. Writing register 17 with bit 4 set clears bit 4, and with bit 5 set clears bit 5. Other status bits are left unchanged.
- R10: A done pulse and a flag-clear write for bit 4 in the same cycle leave bit 4 set.
- R11: Writing control with bit 0 clear returns the controller to idle in the next cycle. It drops xferReq and memRd and clears status bits 0, 4, 5, 8 and 13.
- R12: Writing control with bit 4 set produces fifoClr high for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 5 | Register word offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Read data for regAddr (combinational) |
| memRd | output | 1 | Descriptor memory read request, held until memValid |
| memAddr | output | ADDR_W | Descriptor memory byte address |
| memValid | input | 1 | Read data valid; completes the request |
| memRdata | input | 32 | Descriptor memory read data |
| xferReq | output | 1 | Data mover request, held until xferDone |
| xferHostAddr | output | ADDR_W | Host buffer byte address |
| xferLocalAddr | output | 32 | Local address passed to the mover |
| xferToHost | output | 1 | 1 = device to host, 0 = host to device |
| xferDone | input | 1 | One-cycle completion from the mover |
| fifoClr | output | 1 | One-cycle FIFO reset pulse |

## Verification
Two things can land on the same clock edge. One is the mover's done pulse, which sets the end-of-block flag. The other is a software write to the flag-clear register aimed at that same flag. The bench holds back the automatic mover, waits for a request, and then drives the done pulse and the clear write on the same cycle. It then reads status and expects bit 4 to be set. The same ordering is also checked as a property on every done pulse throughout the run. A stop write that meets a done pulse is the other collision: the stop must win, and the bench checks that with a stop issued mid-transfer.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

  localparam int WORD_W = 32;

  // register word offsets
  localparam logic [4:0] REG_MODE = 5'd8;
  localparam logic [4:0] REG_CTRL = 5'd9;
  localparam logic [4:0] REG_STAT = 5'd16;
  localparam logic [4:0] REG_FCLR = 5'd17;
  localparam logic [4:0] REG_HLO  = 5'd20;
  localparam logic [4:0] REG_HHI  = 5'd21;
  localparam logic [4:0] REG_LOC  = 5'd23;

  localparam logic [15:0] SIG_MARK = 16'h4953;

  typedef enum logic [1:0] {
    ADR_FETCH = 2'd0,
    ADR_W0    = 2'd1,
    ADR_W1    = 2'd2
  } adrSel_e;

  typedef struct packed {
    logic    fetchInit;
    logic    baseFromLink;
    logic    fetchBeat;
    logic    descInit;
    logic    latchW0;
    logic    latchW1;
    logic    nextDesc;
    adrSel_e adrSel;
    logic    setValid;
    logic    setEob;
    logic    setEot;
    logic    setReject;
  } ctlStrobe_t;

endpackage

// File: rtl/dma_chain_regs.sv
module dma_chain_regs
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [4:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  ctlStrobe_t        st,
  input  logic              busy,
  output logic              startPulse,
  output logic              stopPulse,
  output logic              fifoClr,
  output logic [ADDR_W-1:0] descBase,
  output logic [31:0]       localAddr,
  output logic [31:0]       statusWord
);

  logic [31:0] modeReg, hostLo, hostHi, locReg;
  logic        runReg, eob, eot, blkValid, blkReject;
  logic        ctrlWr, fclrWr, flagWipe;

  assign ctrlWr     = regWr && (regAddr == REG_CTRL);
  assign fclrWr     = regWr && (regAddr == REG_FCLR);
  assign startPulse = ctrlWr && regWdata[0] && !busy;
  assign stopPulse  = ctrlWr && !regWdata[0];
  assign flagWipe   = startPulse || stopPulse;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg   <= '0;
      hostLo    <= '0;
      hostHi    <= '0;
      locReg    <= '0;
      runReg    <= 1'b0;
      fifoClr   <= 1'b0;
      eob       <= 1'b0;
      eot       <= 1'b0;
      blkValid  <= 1'b0;
      blkReject <= 1'b0;
    end else begin
      if (regWr) begin
        case (regAddr)
          REG_MODE: modeReg <= regWdata;
          REG_HLO:  hostLo  <= regWdata;
          REG_HHI:  hostHi  <= regWdata;
          REG_LOC:  locReg  <= regWdata;
          REG_CTRL: runReg  <= regWdata[0];
          default: ;
        endcase
      end
      fifoClr <= ctrlWr && regWdata[4];
      if (flagWipe) begin
        eob       <= 1'b0;
        eot       <= 1'b0;
        blkValid  <= 1'b0;
        blkReject <= 1'b0;
      end else begin
        // a new event outranks a software clear in the same cycle
        eob       <= st.setEob | (eob & ~(fclrWr & regWdata[4]));
        eot       <= st.setEot | (eot & ~(fclrWr & regWdata[5]));
        blkValid  <= blkValid | st.setValid;
        blkReject <= blkReject | st.setReject;
      end
    end
  end

  assign statusWord = {16'h0, ~busy, 1'b0, blkReject, 4'b0, blkValid,
                       2'b0, eot, eob, 3'b0, runReg};
  assign localAddr  = locReg;

  generate
    if (ADDR_W > 32) begin : g_wide
      assign descBase = {hostHi[ADDR_W-33:0], hostLo};
    end else begin : g_narrow
      assign descBase = hostLo[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    case (regAddr)
      REG_MODE: regRdata = modeReg;
      REG_CTRL: regRdata = {31'h0, runReg};
      REG_STAT: regRdata = statusWord;
      REG_HLO:  regRdata = hostLo;
      REG_HHI:  regRdata = hostHi;
      REG_LOC:  regRdata = locReg;
      default:  regRdata = '0;
    endcase
  end

endmodule

// File: rtl/dma_chain_dpath.sv
module dma_chain_dpath
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BLK_WORDS  = 128,
  parameter int UNIT_SHIFT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        st,
  input  logic [31:0]       memRdata,
  input  logic [ADDR_W-1:0] descBase,
  output logic [ADDR_W-1:0] memAddr,
  output logic              lastWord,
  output logic              blkOk,
  output logic              w1Cont,
  output logic              w1Link,
  output logic              descLast,
  output logic [ADDR_W-1:0] xferHostAddr,
  output logic              xferToHost
);

  localparam int WIDX_W   = $clog2(BLK_WORDS);
  localparam int DIDX_W   = WIDX_W - 1;
  localparam int MAX_DESC = BLK_WORDS / 2 - 1;

  logic [ADDR_W-1:0] blkBase;
  logic [WIDX_W-1:0] wordIdx;
  logic [DIDX_W-1:0] descIdx;
  logic [15:0]       sumAcc, sigLo, sigHi;
  logic              resvBad;
  logic [31:0]       w0;
  logic              w1Dir;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blkBase <= '0;
      wordIdx <= '0;
      descIdx <= '0;
      sumAcc  <= '0;
      sigLo   <= '0;
      sigHi   <= '0;
      resvBad <= 1'b0;
      w0      <= '0;
      w1Cont  <= 1'b0;
      w1Link  <= 1'b0;
      w1Dir   <= 1'b0;
    end else begin
      if (st.fetchInit) begin
        blkBase <= st.baseFromLink ? (ADDR_W'(memRdata) << UNIT_SHIFT) : descBase;
        wordIdx <= '0;
        sumAcc  <= '0;
        resvBad <= 1'b0;
      end else if (st.fetchBeat) begin
        wordIdx <= wordIdx + 1'b1;
        if (lastWord) begin
          sigLo  <= memRdata[15:0];
          sigHi  <= memRdata[31:16];
          sumAcc <= sumAcc + memRdata[15:0];
        end else begin
          sumAcc <= sumAcc + memRdata[15:0] + memRdata[31:16];
          if ((wordIdx == WIDX_W'(BLK_WORDS - 2)) && (memRdata != '0))
            resvBad <= 1'b1;
        end
      end
      if (st.descInit)      descIdx <= '0;
      else if (st.nextDesc) descIdx <= descIdx + 1'b1;
      if (st.latchW0) w0 <= memRdata;
      if (st.latchW1) begin
        w1Cont <= memRdata[0];
        w1Link <= memRdata[1];
        w1Dir  <= memRdata[8];
      end
    end
  end

  assign lastWord = (wordIdx == WIDX_W'(BLK_WORDS - 1));
  assign descLast = (descIdx == DIDX_W'(MAX_DESC - 1));
  assign blkOk    = (sigLo == SIG_MARK) && (sigHi == sumAcc) && !resvBad;

  always_comb begin
    case (st.adrSel)
      ADR_W0:  memAddr = blkBase + (ADDR_W'(descIdx) << 3);
      ADR_W1:  memAddr = blkBase + (ADDR_W'(descIdx) << 3) + ADDR_W'(4);
      default: memAddr = blkBase + (ADDR_W'(wordIdx) << 2);
    endcase
  end

  assign xferHostAddr = ADDR_W'(w0) << UNIT_SHIFT;
  assign xferToHost   = w1Dir;

endmodule

// File: rtl/dma_chain_fsm.sv
module dma_chain_fsm
  import dma_chain_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       stopPulse,
  input  logic       memValid,
  input  logic       xferDone,
  input  logic       lastWord,
  input  logic       blkOk,
  input  logic       w1Cont,
  input  logic       w1Link,
  input  logic       descLast,
  output ctlStrobe_t st,
  output logic       memRd,
  output logic       xferReq,
  output logic       busy
);

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_RDW0, S_RDW1, S_XFER, S_LINK
  } state_e;

  state_e state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt     = state;
    st      = '0;
    memRd   = 1'b0;
    xferReq = 1'b0;
    case (state)
      S_IDLE: begin
        if (startPulse) begin
          st.fetchInit = 1'b1;
          nxt = S_FETCH;
        end
      end
      S_FETCH: begin
        memRd = 1'b1;
        st.adrSel = ADR_FETCH;
        if (memValid) begin
          st.fetchBeat = 1'b1;
          if (lastWord) nxt = S_CHECK;
        end
      end
      S_CHECK: begin
        if (blkOk) begin
          st.setValid = 1'b1;
          st.descInit = 1'b1;
          nxt = S_RDW0;
        end else begin
          st.setReject = 1'b1;
          st.setEot    = 1'b1;
          nxt = S_IDLE;
        end
      end
      S_RDW0: begin
        memRd = 1'b1;
        st.adrSel = ADR_W0;
        if (memValid) begin
          st.latchW0 = 1'b1;
          nxt = S_RDW1;
        end
      end
      S_RDW1: begin
        memRd = 1'b1;
        st.adrSel = ADR_W1;
        if (memValid) begin
          st.latchW1 = 1'b1;
          nxt = S_XFER;
        end
      end
      S_XFER: begin
        xferReq = 1'b1;
        if (xferDone) begin
          st.setEob = 1'b1;
          if ((w1Link || w1Cont) && !descLast) begin
            st.nextDesc = 1'b1;
            nxt = w1Link ? S_LINK : S_RDW0;
          end else begin
            st.setEot = 1'b1;
            nxt = S_IDLE;
          end
        end
      end
      S_LINK: begin
        memRd = 1'b1;
        st.adrSel = ADR_W0;
        if (memValid) begin
          st.fetchInit    = 1'b1;
          st.baseFromLink = 1'b1;
          nxt = S_FETCH;
        end
      end
      default: nxt = S_IDLE;
    endcase
    // a stop outranks every other event in the cycle
    if (stopPulse) begin
      st  = '0;
      nxt = S_IDLE;
    end
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BLK_WORDS  = 128,
  parameter int UNIT_SHIFT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [4:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              memRd,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memValid,
  input  logic [31:0]       memRdata,
  output logic              xferReq,
  output logic [ADDR_W-1:0] xferHostAddr,
  output logic [31:0]       xferLocalAddr,
  output logic              xferToHost,
  input  logic              xferDone,
  output logic              fifoClr
);

  ctlStrobe_t        st;
  logic              busy, startPulse, stopPulse;
  logic              lastWord, blkOk, w1Cont, w1Link, descLast;
  logic [ADDR_W-1:0] descBase;
  logic [31:0]       statusWord;

  dma_chain_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .st(st), .busy(busy),
    .startPulse(startPulse), .stopPulse(stopPulse), .fifoClr(fifoClr),
    .descBase(descBase), .localAddr(xferLocalAddr), .statusWord(statusWord)
  );

  dma_chain_fsm u_fsm (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .stopPulse(stopPulse),
    .memValid(memValid), .xferDone(xferDone), .lastWord(lastWord),
    .blkOk(blkOk), .w1Cont(w1Cont), .w1Link(w1Link), .descLast(descLast),
    .st(st), .memRd(memRd), .xferReq(xferReq), .busy(busy)
  );

  dma_chain_dpath #(
    .ADDR_W(ADDR_W), .BLK_WORDS(BLK_WORDS), .UNIT_SHIFT(UNIT_SHIFT)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .st(st), .memRdata(memRdata),
    .descBase(descBase), .memAddr(memAddr), .lastWord(lastWord),
    .blkOk(blkOk), .w1Cont(w1Cont), .w1Link(w1Link), .descLast(descLast),
    .xferHostAddr(xferHostAddr), .xferToHost(xferToHost)
  );

endmodule

// File: rtl/dma_chain_chk.sv
module dma_chain_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWr,
  input logic [4:0]        regAddr,
  input logic [31:0]       regWdata,
  input logic              memRd,
  input logic [ADDR_W-1:0] memAddr,
  input logic              xferReq,
  input logic              xferDone,
  input logic              fifoClr,
  input logic [31:0]       statusWord
);

  // R5
  reject_no_xfer_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[13] |-> !xferReq);

  // R11
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 5'd9 && !regWdata[0]) |=> (!xferReq && !memRd && statusWord[15]));

  // R12
  fifo_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoClr |-> $past(regWr && regAddr == 5'd9 && regWdata[4]));

  // R10
  eob_set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xferReq && xferDone && !(regWr && regAddr == 5'd9 && !regWdata[0])) |=> statusWord[4]);

  // R3
  mem_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> (memAddr[1:0] == 2'b00));

  // R7
  eot_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusWord[5]) |-> statusWord[15]);

endmodule

bind dma_chain_ctrl dma_chain_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
  .regWdata(regWdata), .memRd(memRd), .memAddr(memAddr),
  .xferReq(xferReq), .xferDone(xferDone), .fifoClr(fifoClr),
  .statusWord(statusWord)
);

// File: tb/sim_dma_chain_ctrl.sv
module sim_dma_chain_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        memRd;
  logic [31:0] memAddr;
  logic        memValid = 1'b0;
  logic [31:0] memRdata = '0;
  logic        xferReq;
  logic [31:0] xferHostAddr, xferLocalAddr;
  logic        xferToHost;
  logic        fifoClr;
  logic        autoDone = 1'b0;
  logic        manDone = 1'b0;
  logic        autoMode = 1'b1;
  logic [2:0]  doneCnt = '0;
  logic        xferDone;

  assign xferDone = autoDone | manDone;

  always #5 clk = ~clk;

  dma_chain_ctrl u0 (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .memRd(memRd),
    .memAddr(memAddr), .memValid(memValid), .memRdata(memRdata),
    .xferReq(xferReq), .xferHostAddr(xferHostAddr),
    .xferLocalAddr(xferLocalAddr), .xferToHost(xferToHost),
    .xferDone(xferDone), .fifoClr(fifoClr)
  );

  logic [31:0] mem [0:1023];
  logic [31:0] rdLog [0:1023];
  int          rdCnt = 0;
  logic [31:0] xfHost [0:15];
  logic [31:0] xfLoc [0:15];
  logic        xfDir [0:15];
  int          xfCnt = 0;
  int          errCnt = 0;
  int          chkCnt = 0;
  bit          finished = 0;

  // memory model: one request answered every other cycle
  always @(posedge clk) begin
    memValid <= memRd && !memValid;
    memRdata <= mem[memAddr[11:2]];
    if (memRd && memValid) begin
      if (rdCnt < 1024) rdLog[rdCnt] <= memAddr;
      rdCnt <= rdCnt + 1;
    end
  end

  // data mover model
  always @(posedge clk) begin
    if (autoMode && xferReq && !autoDone) begin
      if (doneCnt == 3'd3) begin
        autoDone <= 1'b1;
        doneCnt  <= '0;
      end else doneCnt <= doneCnt + 1'b1;
    end else autoDone <= 1'b0;
    if (xferReq && xferDone) begin
      if (xfCnt < 16) begin
        xfHost[xfCnt] <= xferHostAddr;
        xfLoc[xfCnt]  <= xferLocalAddr;
        xfDir[xfCnt]  <= xferToHost;
      end
      xfCnt <= xfCnt + 1;
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic clearMem();
    for (int i = 0; i < 1024; i++) mem[i] = '0;
  endtask

  task automatic setDesc(int blk, int idx, logic [31:0] w0, logic [31:0] w1);
    mem[blk*128 + 2*idx]     = w0;
    mem[blk*128 + 2*idx + 1] = w1;
  endtask

  task automatic seal(int blk);
    logic [15:0] s;
    s = 16'h4953;
    for (int w = 0; w < 127; w++)
      s = s + mem[blk*128 + w][15:0] + mem[blk*128 + w][31:16];
    mem[blk*128 + 127] = {s, 16'h4953};
  endtask

  task automatic startChan(logic [31:0] base, logic [31:0] loc);
    regWrite(5'd9, 32'h0);
    regWrite(5'd20, base);
    regWrite(5'd23, loc);
    regWrite(5'd9, 32'h1);
  endtask

  task automatic waitEot(output logic [31:0] s);
    s = '0;
    for (int i = 0; i < 5000; i++) begin
      regRead(5'd16, s);
      if (s[5]) break;
    end
  endtask

  task automatic t_reset();
    logic [31:0] s;
    regRead(5'd16, s);
    check("R1 status", s, 32'h8000);
    check("R1 memRd", {31'h0, memRd}, 0);
    check("R1 xferReq", {31'h0, xferReq}, 0);
    check("R1 fifoClr", {31'h0, fifoClr}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] s;
    regWrite(5'd8, 32'h25);
    regWrite(5'd20, 32'h0010_0000);
    regWrite(5'd21, 32'h0000_0007);
    regWrite(5'd23, 32'h0000_A400);
    regRead(5'd8, s);  check("R2 mode", s, 32'h25);
    regRead(5'd20, s); check("R2 host low", s, 32'h0010_0000);
    regRead(5'd21, s); check("R2 host high", s, 32'h7);
    regRead(5'd23, s); check("R2 local", s, 32'hA400);
  endtask

  task automatic t_badSig();
    logic [31:0] s;
    int r0, x0;
    clearMem();
    setDesc(0, 0, 32'h0302_0100, 32'h0);
    mem[127] = 32'hFF00_AA00;
    r0 = rdCnt; x0 = xfCnt;
    startChan(32'h0010_0000, 32'hA400);
    waitEot(s);
    repeat (20) @(negedge clk);
    regRead(5'd16, s);
    check("R5 bad signature status", s, 32'hA021);
    check("R5 no transfer", xfCnt - x0, 0);
    check("R3 full block read", rdCnt - r0, 128);
  endtask

  task automatic t_badSum();
    logic [31:0] s;
    clearMem();
    setDesc(0, 0, 32'h8000, 32'h100);
    seal(0);
    mem[127] = mem[127] ^ 32'h0001_0000;
    startChan(32'h0010_0000, 32'hA400);
    waitEot(s);
    check("R4 checksum mismatch rejected", s, 32'hA021);
    clearMem();
    setDesc(0, 0, 32'h8000, 32'h100);
    mem[126] = 32'h0000_0001;
    seal(0);
    startChan(32'h0010_0000, 32'hA400);
    waitEot(s);
    check("R4 reserved word nonzero rejected", s, 32'hA021);
  endtask

  task automatic t_single();
    logic [31:0] s;
    int r0, x0;
    clearMem();
    setDesc(0, 0, 32'h8000, 32'h100);
    seal(0);
    r0 = rdCnt; x0 = xfCnt;
    startChan(32'h0010_0000, 32'hA400);
    waitEot(s);
    check("R4 R7 accepted and finished", s, 32'h8131);
    check("R7 one transfer", xfCnt - x0, 1);
    check("R6 host address", xfHost[x0], 32'h0080_0000);
    check("R6 direction to host", {31'h0, xfDir[x0]}, 1);
    check("R2 local address passed", xfLoc[x0], 32'hA400);
    check("R3 read count", rdCnt - r0, 130);
    check("R3 first fetch address", rdLog[r0], 32'h0010_0000);
    check("R3 last fetch address", rdLog[r0+127], 32'h0010_01FC);
    check("R6 word0 address", rdLog[r0+128], 32'h0010_0000);
    check("R6 word1 address", rdLog[r0+129], 32'h0010_0004);
    regWrite(5'd17, 32'h10);
    regRead(5'd16, s);
    check("R9 clear end of block", s, 32'h8121);
    regWrite(5'd17, 32'h20);
    regRead(5'd16, s);
    check("R9 clear end of transfer", s, 32'h8101);
  endtask

  task automatic t_link();
    logic [31:0] s;
    int r0, x0;
    clearMem();
    setDesc(0, 0, 32'h8000, 32'h111);
    setDesc(0, 1, 32'h8010, 32'h112);
    setDesc(0, 2, 32'h1002, 32'h0);
    seal(0);
    setDesc(1, 0, 32'h8020, 32'h011);
    setDesc(1, 1, 32'h8030, 32'h010);
    seal(1);
    r0 = rdCnt; x0 = xfCnt;
    startChan(32'h0010_0000, 32'h19000);
    waitEot(s);
    check("R8 chain finished", s, 32'h8131);
    check("R8 four transfers", xfCnt - x0, 4);
    check("R7 transfer 0", xfHost[x0], 32'h0080_0000);
    check("R7 transfer 1", xfHost[x0+1], 32'h0080_1000);
    check("R8 transfer 2", xfHost[x0+2], 32'h0080_2000);
    check("R8 transfer 3", xfHost[x0+3], 32'h0080_3000);
    check("R6 dir 1", {31'h0, xfDir[x0+1]}, 1);
    check("R6 dir 2", {31'h0, xfDir[x0+2]}, 0);
    check("R8 link entry read", rdLog[r0+132], 32'h0010_0010);
    check("R8 second block fetch", rdLog[r0+133], 32'h0010_0200);
  endtask

  task automatic t_collide();
    logic [31:0] s;
    clearMem();
    setDesc(0, 0, 32'h8000, 32'h100);
    seal(0);
    autoMode = 1'b0;
    startChan(32'h0010_0000, 32'hA400);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (xferReq) break;
    end
    @(negedge clk);
    manDone = 1'b1;
    regWr = 1'b1; regAddr = 5'd17; regWdata = 32'h10;
    @(negedge clk);
    manDone = 1'b0;
    regWr = 1'b0;
    regRead(5'd16, s);
    check("R10 set wins over clear", {31'h0, s[4]}, 1);
    regWrite(5'd17, 32'h10);
    regRead(5'd16, s);
    check("R9 later clear works", {31'h0, s[4]}, 0);
    autoMode = 1'b1;
  endtask

  task automatic t_stop();
    logic [31:0] s;
    int x0;
    clearMem();
    setDesc(0, 0, 32'h8000, 32'h111);
    setDesc(0, 1, 32'h8010, 32'h110);
    seal(0);
    autoMode = 1'b0;
    startChan(32'h0010_0000, 32'hA400);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (xferReq) break;
    end
    x0 = xfCnt;
    regWr = 1'b1; regAddr = 5'd9; regWdata = 32'h0;
    @(negedge clk);
    regWr = 1'b0;
    regAddr = 5'd16;
    #1;
    check("R11 request dropped", {31'h0, xferReq}, 0);
    check("R11 no memory read", {31'h0, memRd}, 0);
    check("R11 status cleared", regRdata, 32'h8000);
    repeat (10) @(negedge clk);
    check("R11 nothing moved after stop", xfCnt - x0, 0);
    autoMode = 1'b1;
  endtask

  task automatic t_fifo();
    @(negedge clk);
    regWr = 1'b1; regAddr = 5'd9; regWdata = 32'h10;
    @(negedge clk);
    regWr = 1'b0;
    check("R12 pulse high", {31'h0, fifoClr}, 1);
    @(negedge clk);
    check("R12 pulse one cycle", {31'h0, fifoClr}, 0);
  endtask

  initial begin
    clearMem();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_badSig();
    t_badSum();
    t_single();
    t_link();
    t_collide();
    t_stop();
    t_fifo();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    errCnt++;
    chkCnt++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

endmodule